// File: doc/BRIEF.md
# Suspend-to-RAM Entry Sequencer

This block orders the steps a memory controller with registered memory modules takes when the system goes into suspend-to-RAM. When a sleep request arrives, the block first asserts an active-low clock-stop output. One slow real-time-clock period later it drives the module and bus reset low and isolates the I/O pad ring, which will lose power while the core stays up. The memory clocks keep running for a fixed number of fast clocks after that, then stop. One or more clocks later the block raises a power-off request. The memory I/O ring is never isolated.

If power-good falls before the sequence completes, reset is asserted and the memory clocks are gated in the same cycle. An error flag is then set and the block moves to the powered-off state.

When power-good returns after power-off, the block resumes. It re-enables the memory clocks first, releases reset and pad isolation after a hold time, and releases clock-stop one cycle after that.

Top module: `s3_entry_seq`

## Requirements
- R1: After rst_ni is released, clk_stop_no=1, mod_rst_no=1, pad_iso_o=0, mem_clk_en_o=1, pwr_off_req_o=0 and err_o=0.
- R2: The request is accepted only on a clock edge where sleep_req_i, rtc_tick_i and pwr_good_i are all 1. In the cycle after that edge, clk_stop_no is 0 and all other outputs are unchanged.
- R3: mod_rst_no goes to 0 and pad_iso_o goes to 1 in the cycle after the edge that samples the RTC_TICKS-th tick following clock-stop. Before that edge they do not change.
- R4: mem_clk_en_o stays 1 for exactly CLK_HOLD cycles with reset asserted, and is 0 from then on.
- R5: pwr_off_req_o rises exactly OFF_DELAY cycles after mem_clk_en_o falls, so it follows the clock removal by at least one cycle.
- R6: mem_clk_en_o is never 0 while mod_rst_no is 1, and mod_rst_no is never 0 while clk_stop_no is 1.
- R7: In the idle state, a sleep request on an edge without a tick, or with pwr_good_i at 0, leaves every output unchanged.
- R8: If pwr_good_i is 0 while clock-stop, reset or clock-off is in progress, mod_rst_no=0 and mem_clk_en_o=0 in that same cycle. From the next cycle, pwr_off_req_o=1 and err_o=1.
- R9: In the powered-off state, a rise of pwr_good_i makes mem_clk_en_o=1 in the next cycle while reset, isolation and clock-stop stay asserted. Reset and isolation are released RESUME_HOLD cycles later, and clk_stop_no returns to 1 one cycle after that.
- R10: err_o stays set until the next accepted sleep request, and clears in the cycle that clock-stop is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Level request to enter suspend |
| rtc_tick_i | input | 1 | One-cycle enable per slow RTC period |
| pwr_good_i | input | 1 | Supply good indication |
| clk_stop_no | output | 1 | Active-low clock-stop |
| mod_rst_no | output | 1 | Active-low bus and memory-module reset |
| pad_iso_o | output | 1 | I/O pad ring isolation enable |
| mem_clk_en_o | output | 1 | Memory clock enable |
| pwr_off_req_o | output | 1 | Request to shut the supply off |
| err_o | output | 1 | Power-good was lost mid-sequence |

## Verification
All outputs except the power-good override are decoded from registered state. Each result therefore appears in the cycle after the edge that samples its cause. The power-good override on reset and memory clock acts within the same cycle, before any edge. The bench drives inputs shortly after a rising edge and reads outputs just before the next one. It counts CLK_HOLD, OFF_DELAY and RESUME_HOLD observation windows one cycle at a time and checks that each output is still held at every cycle but the last. Same-cycle override checks read the outputs a delta after pwr_good_i drops, with no edge in between.

// File: rtl/s3_seq_pkg.sv
package s3_seq_pkg;
  localparam int unsigned NUM_ST = 6;

  localparam int unsigned B_IDLE   = 0;
  localparam int unsigned B_STOP   = 1;
  localparam int unsigned B_RST    = 2;
  localparam int unsigned B_CLKOFF = 3;
  localparam int unsigned B_POFF   = 4;
  localparam int unsigned B_RESUME = 5;

  typedef logic [NUM_ST-1:0] seq_st_t;

  localparam seq_st_t ST_IDLE   = seq_st_t'(1) << B_IDLE;
  localparam seq_st_t ST_STOP   = seq_st_t'(1) << B_STOP;
  localparam seq_st_t ST_RST    = seq_st_t'(1) << B_RST;
  localparam seq_st_t ST_CLKOFF = seq_st_t'(1) << B_CLKOFF;
  localparam seq_st_t ST_POFF   = seq_st_t'(1) << B_POFF;
  localparam seq_st_t ST_RESUME = seq_st_t'(1) << B_RESUME;
endpackage

// File: rtl/s3_span_cnt.sv
module s3_span_cnt #(
  parameter int unsigned MAX = 4,
  localparam int unsigned CW = (MAX < 2) ? 1 : $clog2(MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CMAX = CW'(MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (en_i && cnt_o != CMAX)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/s3_seq_fsm.sv
module s3_seq_fsm
  import s3_seq_pkg::*;
#(
  parameter int unsigned RTC_TICKS   = 1,
  parameter int unsigned CLK_HOLD    = 4,
  parameter int unsigned OFF_DELAY   = 1,
  parameter int unsigned RESUME_HOLD = 4,
  parameter int unsigned RW = 1,
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sleep_req_i,
  input  logic          rtc_tick_i,
  input  logic          pwr_good_i,
  input  logic [RW-1:0] rtc_cnt_i,
  input  logic [CW-1:0] cyc_cnt_i,
  output seq_st_t       st_o,
  output logic          st_chg_o,
  output logic          err_o
);
  localparam logic [RW-1:0] RTC_LAST  = RW'(RTC_TICKS - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(CLK_HOLD - 1);
  localparam logic [CW-1:0] OFF_LAST  = CW'(OFF_DELAY - 1);
  localparam logic [CW-1:0] RES_LAST  = CW'(RESUME_HOLD);

  seq_st_t st_q, st_d;
  logic    pg_q;
  logic    in_seq, pg_lost, pg_rise, accept;

  assign in_seq  = st_q[B_STOP] | st_q[B_RST] | st_q[B_CLKOFF];
  assign pg_lost = in_seq & ~pwr_good_i;
  assign pg_rise = pwr_good_i & ~pg_q;
  assign accept  = st_q[B_IDLE] & sleep_req_i & rtc_tick_i & pwr_good_i;

  always_comb begin
    st_d = st_q;
    unique case (1'b1)
      st_q[B_IDLE]:   if (accept) st_d = ST_STOP;
      st_q[B_STOP]:   if (!pwr_good_i) st_d = ST_POFF;
                      else if (rtc_tick_i && rtc_cnt_i == RTC_LAST) st_d = ST_RST;
      st_q[B_RST]:    if (!pwr_good_i) st_d = ST_POFF;
                      else if (cyc_cnt_i == HOLD_LAST) st_d = ST_CLKOFF;
      st_q[B_CLKOFF]: if (!pwr_good_i) st_d = ST_POFF;
                      else if (cyc_cnt_i == OFF_LAST) st_d = ST_POFF;
      st_q[B_POFF]:   if (pg_rise) st_d = ST_RESUME;
      st_q[B_RESUME]: if (cyc_cnt_i == RES_LAST) st_d = ST_IDLE;
      default:        st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      pg_q  <= 1'b0;
      err_o <= 1'b0;
    end else begin
      st_q <= st_d;
      pg_q <= pwr_good_i;
      if (pg_lost)     err_o <= 1'b1;
      else if (accept) err_o <= 1'b0;
    end
  end

  assign st_o     = st_q;
  assign st_chg_o = (st_d != st_q);

  assert_state_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(st_q) == 1);

  assert_loss_to_poff_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_lost |=> (st_q[B_POFF] && err_o));

  assert_err_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !err_o);
endmodule

// File: rtl/s3_out_dec.sv
module s3_out_dec
  import s3_seq_pkg::*;
#(
  parameter int unsigned RESUME_HOLD = 4,
  parameter int unsigned CW = 3
) (
  input  seq_st_t       st_i,
  input  logic [CW-1:0] cyc_cnt_i,
  input  logic          pwr_good_i,
  output logic          clk_stop_no,
  output logic          mod_rst_no,
  output logic          pad_iso_o,
  output logic          mem_clk_en_o,
  output logic          pwr_off_req_o
);
  localparam logic [CW-1:0] RES_HOLD = CW'(RESUME_HOLD);

  logic pg_force, rst_on, clk_off;

  // immediate override when supply fails mid-sequence
  assign pg_force = ~pwr_good_i & (st_i[B_STOP] | st_i[B_RST] | st_i[B_CLKOFF]);

  assign rst_on = st_i[B_RST] | st_i[B_CLKOFF] | st_i[B_POFF]
                | (st_i[B_RESUME] & (cyc_cnt_i < RES_HOLD)) | pg_force;
  assign clk_off = st_i[B_CLKOFF] | st_i[B_POFF] | pg_force;

  assign clk_stop_no   = st_i[B_IDLE];
  assign mod_rst_no    = ~rst_on;
  assign pad_iso_o     = rst_on;
  assign mem_clk_en_o  = ~clk_off;
  assign pwr_off_req_o = st_i[B_POFF];
endmodule

// File: rtl/s3_entry_seq.sv
module s3_entry_seq
  import s3_seq_pkg::*;
#(
  parameter int unsigned RTC_TICKS   = 1,
  parameter int unsigned CLK_HOLD    = 4,
  parameter int unsigned OFF_DELAY   = 1,
  parameter int unsigned RESUME_HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic rtc_tick_i,
  input  logic pwr_good_i,
  output logic clk_stop_no,
  output logic mod_rst_no,
  output logic pad_iso_o,
  output logic mem_clk_en_o,
  output logic pwr_off_req_o,
  output logic err_o
);
  localparam int unsigned CYC_MAX_A = (CLK_HOLD > OFF_DELAY) ? CLK_HOLD : OFF_DELAY;
  localparam int unsigned CYC_MAX   = (CYC_MAX_A > RESUME_HOLD) ? CYC_MAX_A : RESUME_HOLD;
  localparam int unsigned RW = (RTC_TICKS < 2) ? 1 : $clog2(RTC_TICKS + 1);
  localparam int unsigned CW = (CYC_MAX < 2) ? 1 : $clog2(CYC_MAX + 1);

  seq_st_t       st;
  logic          st_chg;
  logic [RW-1:0] rtc_cnt;
  logic [CW-1:0] cyc_cnt;

  s3_span_cnt #(.MAX(RTC_TICKS)) u_rtc_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_chg),
    .en_i  (st[B_STOP] & rtc_tick_i),
    .cnt_o (rtc_cnt)
  );

  s3_span_cnt #(.MAX(CYC_MAX)) u_cyc_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (st_chg),
    .en_i  (st[B_RST] | st[B_CLKOFF] | st[B_RESUME]),
    .cnt_o (cyc_cnt)
  );

  s3_seq_fsm #(
    .RTC_TICKS  (RTC_TICKS),
    .CLK_HOLD   (CLK_HOLD),
    .OFF_DELAY  (OFF_DELAY),
    .RESUME_HOLD(RESUME_HOLD),
    .RW         (RW),
    .CW         (CW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_req_i(sleep_req_i),
    .rtc_tick_i (rtc_tick_i),
    .pwr_good_i (pwr_good_i),
    .rtc_cnt_i  (rtc_cnt),
    .cyc_cnt_i  (cyc_cnt),
    .st_o       (st),
    .st_chg_o   (st_chg),
    .err_o      (err_o)
  );

  s3_out_dec #(
    .RESUME_HOLD(RESUME_HOLD),
    .CW         (CW)
  ) u_dec (
    .st_i         (st),
    .cyc_cnt_i    (cyc_cnt),
    .pwr_good_i   (pwr_good_i),
    .clk_stop_no  (clk_stop_no),
    .mod_rst_no   (mod_rst_no),
    .pad_iso_o    (pad_iso_o),
    .mem_clk_en_o (mem_clk_en_o),
    .pwr_off_req_o(pwr_off_req_o)
  );

  assert_clk_off_needs_rst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_clk_en_o |-> !mod_rst_no);

  assert_rst_needs_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mod_rst_no |-> !clk_stop_no);

  assert_stop_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_stop_no) |-> $past(rtc_tick_i && sleep_req_i && pwr_good_i));

  assert_rst_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(mod_rst_no) && pwr_good_i) |-> $past(rtc_tick_i));

  assert_poff_after_clkoff_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_off_req_o) |-> $past(!mem_clk_en_o));
endmodule

// File: tb/tb_s3_entry_seq.sv
module tb_s3_entry_seq;
  localparam int unsigned RTC_TICKS   = 2;
  localparam int unsigned CLK_HOLD    = 4;
  localparam int unsigned OFF_DELAY   = 2;
  localparam int unsigned RESUME_HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, rtc_tick = 1'b0, pwr_good = 1'b1;
  logic clk_stop_n, mod_rst_n, pad_iso, mem_clk_en, pwr_off_req, err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  s3_entry_seq #(
    .RTC_TICKS(RTC_TICKS), .CLK_HOLD(CLK_HOLD),
    .OFF_DELAY(OFF_DELAY), .RESUME_HOLD(RESUME_HOLD)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .rtc_tick_i(rtc_tick),
    .pwr_good_i(pwr_good), .clk_stop_no(clk_stop_n), .mod_rst_no(mod_rst_n),
    .pad_iso_o(pad_iso), .mem_clk_en_o(mem_clk_en), .pwr_off_req_o(pwr_off_req),
    .err_o(err)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk_all(input string req, input logic cs, input logic rs, input logic iso,
                         input logic ce, input logic po);
    chk(req, "clk_stop_no", clk_stop_n, cs);
    chk(req, "mod_rst_no", mod_rst_n, rs);
    chk(req, "pad_iso_o", pad_iso, iso);
    chk(req, "mem_clk_en_o", mem_clk_en, ce);
    chk(req, "pwr_off_req_o", pwr_off_req, po);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk_all("R1", 1, 1, 0, 1, 0);
    chk("R1", "err_o", err, 1'b0);
  endtask

  task automatic t_idle_ignore();
    sleep_req = 1'b1;
    repeat (3) begin
      step();
      chk_all("R7", 1, 1, 0, 1, 0);
    end
    pwr_good = 1'b0;
    rtc_tick = 1'b1;
    step();
    rtc_tick = 1'b0;
    step();
    chk_all("R7", 1, 1, 0, 1, 0);
    pwr_good = 1'b1;
    sleep_req = 1'b0;
    step();
  endtask

  task automatic t_enter_stop(input string req);
    sleep_req = 1'b1;
    rtc_tick = 1'b1;
    step();
    rtc_tick = 1'b0;
    chk_all(req, 0, 1, 0, 1, 0);
  endtask

  task automatic t_normal_entry();
    t_enter_stop("R2");
    for (int t = 0; t < RTC_TICKS - 1; t++) begin
      repeat (2) step();
      rtc_tick = 1'b1;
      step();
      rtc_tick = 1'b0;
      chk("R3", "mod_rst_no before last tick", mod_rst_n, 1'b1);
    end
    repeat (3) begin
      step();
      chk("R3", "mod_rst_no no tick", mod_rst_n, 1'b1);
    end
    rtc_tick = 1'b1;
    step();
    rtc_tick = 1'b0;
    chk_all("R3", 0, 0, 1, 1, 0);
    for (int i = 1; i < CLK_HOLD; i++) begin
      step();
      chk("R4", "mem_clk_en_o held", mem_clk_en, 1'b1);
    end
    step();
    chk("R4", "mem_clk_en_o off", mem_clk_en, 1'b0);
    chk("R6", "mod_rst_no with clk off", mod_rst_n, 1'b0);
    chk("R5", "pwr_off_req_o early", pwr_off_req, 1'b0);
    sleep_req = 1'b0;
    for (int i = 1; i < OFF_DELAY; i++) begin
      step();
      chk("R5", "pwr_off_req_o wait", pwr_off_req, 1'b0);
    end
    step();
    chk_all("R5", 0, 0, 1, 0, 1);
    chk("R5", "err_o", err, 1'b0);
  endtask

  task automatic t_resume();
    pwr_good = 1'b0;
    repeat (2) step();
    chk_all("R9", 0, 0, 1, 0, 1);
    pwr_good = 1'b1;
    step();
    chk_all("R9", 0, 0, 1, 1, 0);
    for (int i = 1; i < RESUME_HOLD; i++) begin
      step();
      chk("R9", "mod_rst_no held", mod_rst_n, 1'b0);
    end
    step();
    chk_all("R9", 0, 1, 0, 1, 0);
    step();
    chk_all("R9", 1, 1, 0, 1, 0);
  endtask

  task automatic t_early_loss();
    t_enter_stop("R2");
    pwr_good = 1'b0;
    #1;
    chk("R8", "mod_rst_no same cycle", mod_rst_n, 1'b0);
    chk("R8", "mem_clk_en_o same cycle", mem_clk_en, 1'b0);
    chk("R8", "err_o not yet", err, 1'b0);
    sleep_req = 1'b0;
    step();
    chk("R8", "pwr_off_req_o", pwr_off_req, 1'b1);
    chk("R8", "err_o", err, 1'b1);
    chk("R6", "mod_rst_no", mod_rst_n, 1'b0);
    t_resume();
    chk("R10", "err_o kept in idle", err, 1'b1);
    t_enter_stop("R10");
    chk("R10", "err_o cleared", err, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_idle_ignore();
    t_normal_entry();
    t_resume();
    t_early_loss();
    repeat (2) step();
    finish_run();
  end

  initial begin
    #(20 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end
endmodule